// File: doc/BRIEF.md
# Nine-Bit Addressable Serial Receiver

This block receives asynchronous serial frames of eleven bit times: a low start bit, eight data bits sent least significant bit first, a ninth bit, and a high stop bit. The ninth bit tells the frame's type. A value of 1 marks a node address and 0 marks payload. Several receivers can share one line. Each one turns on its address filter, so it raises its completion flag only for address frames. When software sees its own address, it turns the filter off to take the payload that follows.

The line is sampled on a 16x oversampling tick that comes from outside the block. A start edge is confirmed at mid-bit. Each later bit is resolved by a two-of-three vote around mid-bit. A finished character is reported through a sticky completion flag, which is kept apart from the control inputs. That flag stays set until a one-cycle clear strobe removes it. While the flag is set, a newly finished frame does not overwrite the held character.

Top module: `mp_uart_rx`

## Requirements
- R1: A frame is start(0), eight data bits with the least significant first, a ninth bit, then stop(1). After a frame is accepted, `rx_byte` holds the eight data bits and `rx_bit9` holds the ninth bit.
- R2: Frames are taken only while `rx_en` is 1. A frame sent while it is 0 leaves `rx_done`, `rx_byte` and `rx_bit9` unchanged, and dropping `rx_en` returns the receiver to idle on the next cycle.
- R3: With `addr_filt_en` = 1, only a frame whose ninth bit is 1 and whose stop bit is high sets `rx_done`. Any other frame changes no output.
- R4: With `addr_filt_en` = 0, every frame that ends sets `rx_done`, whatever its ninth bit.
- R5: With `addr_filt_en` = 0, a frame whose stop bit reads low still sets `rx_done` and drives `frame_err` to 1. A frame with a high stop bit drives `frame_err` to 0.
- R6: A falling edge is accepted as a start bit only if the line is still low on the 8th oversample tick. Otherwise the receiver goes back to idle and reports nothing.
- R7: Each data bit, the ninth bit and the stop bit are decided by the majority of three consecutive oversample ticks around mid-bit. A single opposite sample does not change the bit.
- R8: If `rx_done` is still set when a new frame ends (and no clear arrives in that cycle), the new frame is dropped and the held outputs keep their values.
- R9: `rx_done` stays set until `flag_clr` is high for a cycle, and it reads 0 on the following cycle. A clear and a completion in the same cycle leave it set.
- R10: After reset, `rx_done`, `rx_byte`, `rx_bit9` and `frame_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| rx_en | input | 1 | Receive enable |
| addr_filt_en | input | 1 | Address filter enable |
| os_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| flag_clr | input | 1 | One-cycle strobe that clears `rx_done` |
| rx_byte | output | 8 | Last accepted data byte |
| rx_bit9 | output | 1 | Ninth bit of the last accepted frame |
| rx_done | output | 1 | Sticky receive-complete flag |
| frame_err | output | 1 | Stop bit of the last accepted frame read low |

## Verification
The assertions check the following on every cycle:
- the flag's set, hold and clear rules, including a clear that lands in the same cycle as a completion;
- that the held byte stays stable while the flag is up;
- that the receiver goes idle once enable drops;
- that a rise of the flag under filtering always comes with a marked ninth bit and a good stop bit.

Only the bench's frame scenarios can show that the byte is assembled least significant bit first, that the majority vote outvotes a one-tick glitch, that a short low pulse is rejected as a false start, and that an overrun drops the later frame.

// File: rtl/mp_uart_rx_pkg.sv
package mp_uart_rx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_BITS  = 2'd2
    } rx_state_e;

    // Trailing part of a finished frame: ninth bit and sampled stop level.
    typedef struct packed {
        logic addr_mark;
        logic stop_ok;
    } rx_tail_t;

    function automatic logic vote3(input logic [2:0] s);
        return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
    endfunction

endpackage

// File: rtl/mp_uart_rx_sampler.sv
module mp_uart_rx_sampler #(
    parameter int SYNC_STAGES = 2,
    parameter int VOTE_DEPTH  = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic rx_in,
    input  logic tick,
    output logic line_s,
    output logic vote
);
    import mp_uart_rx_pkg::*;

    logic [SYNC_STAGES-1:0] sync_q;
    logic [VOTE_DEPTH-1:0]  hist_q;

    // Metastability chain, idle high.
    always_ff @(posedge clk) begin
        if (rst) sync_q <= '1;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], rx_in};
    end

    assign line_s = sync_q[SYNC_STAGES-1];

    // Samples taken on oversample ticks only.
    always_ff @(posedge clk) begin
        if (rst)       hist_q <= '1;
        else if (tick) hist_q <= {hist_q[VOTE_DEPTH-2:0], line_s};
    end

    assign vote = vote3(hist_q[2:0]);

endmodule

// File: rtl/mp_uart_rx_fsm.sv
module mp_uart_rx_fsm #(
    parameter int DATA_W = 8,
    parameter int OSR    = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       rx_en,
    input  logic                       tick,
    input  logic                       line_s,
    input  logic                       vote,
    output logic                       frm_done,
    output logic [DATA_W-1:0]          frm_data,
    output mp_uart_rx_pkg::rx_tail_t   frm_tail,
    output logic                       busy
);
    import mp_uart_rx_pkg::*;

    localparam int PH_W  = $clog2(OSR);
    localparam int IDX_W = $clog2(DATA_W + 2);
    localparam logic [PH_W-1:0]  MID_P    = PH_W'(OSR / 2 - 1);
    localparam logic [PH_W-1:0]  VOTE_P   = PH_W'(OSR / 2);
    localparam logic [PH_W-1:0]  LAST_P   = PH_W'(OSR - 1);
    localparam logic [IDX_W-1:0] STOP_IDX = IDX_W'(DATA_W + 1);

    rx_state_e         state_q;
    logic [PH_W-1:0]   phase_q;
    logic [IDX_W-1:0]  bitno_q;
    logic [DATA_W:0]   shreg_q;
    rx_tail_t          tail_q;
    logic              done_q;
    logic [PH_W-1:0]   phase_inc;

    assign phase_inc = (phase_q == LAST_P) ? '0 : phase_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            phase_q <= '0;
            bitno_q <= '0;
            shreg_q <= '0;
            tail_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!rx_en) begin
                state_q <= ST_IDLE;
                phase_q <= '0;
            end else if (tick) begin
                unique case (state_q)
                    ST_IDLE: begin
                        if (!line_s) begin
                            state_q <= ST_START;
                            phase_q <= PH_W'(1);
                        end
                    end
                    ST_START: begin
                        phase_q <= phase_inc;
                        if (phase_q == MID_P && line_s) begin
                            state_q <= ST_IDLE;
                            phase_q <= '0;
                        end else if (phase_q == LAST_P) begin
                            state_q <= ST_BITS;
                            bitno_q <= '0;
                        end
                    end
                    ST_BITS: begin
                        phase_q <= phase_inc;
                        if (phase_q == VOTE_P) begin
                            if (bitno_q == STOP_IDX) begin
                                tail_q.addr_mark <= shreg_q[DATA_W];
                                tail_q.stop_ok   <= vote;
                                done_q           <= 1'b1;
                                state_q          <= ST_IDLE;
                                phase_q          <= '0;
                            end else begin
                                shreg_q <= {vote, shreg_q[DATA_W:1]};
                            end
                        end
                        if (phase_q == LAST_P) bitno_q <= bitno_q + 1'b1;
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    assign frm_done = done_q;
    assign frm_data = shreg_q[DATA_W-1:0];
    assign frm_tail = tail_q;
    assign busy     = (state_q != ST_IDLE);

endmodule

// File: rtl/mp_uart_rx_result.sv
module mp_uart_rx_result #(
    parameter int DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     frm_done,
    input  logic [DATA_W-1:0]        frm_data,
    input  mp_uart_rx_pkg::rx_tail_t frm_tail,
    input  logic                     filt_en,
    input  logic                     flag_clr,
    output logic                     take,
    output logic [DATA_W-1:0]        rx_byte,
    output logic                     rx_bit9,
    output logic                     frame_err,
    output logic                     rx_done
);
    import mp_uart_rx_pkg::*;

    logic qualifies;
    logic room;

    assign qualifies = filt_en ? (frm_tail.addr_mark & frm_tail.stop_ok) : 1'b1;
    assign room      = ~rx_done | flag_clr;
    assign take      = frm_done & qualifies & room;

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_byte   <= '0;
            rx_bit9   <= 1'b0;
            frame_err <= 1'b0;
            rx_done   <= 1'b0;
        end else begin
            rx_done <= (rx_done & ~flag_clr) | take;
            if (take) begin
                rx_byte   <= frm_data;
                rx_bit9   <= frm_tail.addr_mark;
                frame_err <= ~frm_tail.stop_ok;
            end
        end
    end

endmodule

// File: rtl/mp_uart_rx.sv
module mp_uart_rx #(
    parameter int DATA_W      = 8,
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_line,
    input  logic              rx_en,
    input  logic              addr_filt_en,
    input  logic              os_tick,
    input  logic              flag_clr,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_bit9,
    output logic              rx_done,
    output logic              frame_err
);
    import mp_uart_rx_pkg::*;

    logic              line_s;
    logic              vote;
    logic              frm_done;
    logic [DATA_W-1:0] frm_data;
    rx_tail_t          frm_tail;
    logic              busy;
    logic              take;

    mp_uart_rx_sampler #(.SYNC_STAGES(SYNC_STAGES), .VOTE_DEPTH(3)) u_smp (
        .clk(clk), .rst(rst), .rx_in(rx_line), .tick(os_tick),
        .line_s(line_s), .vote(vote)
    );

    mp_uart_rx_fsm #(.DATA_W(DATA_W), .OSR(OSR)) u_fsm (
        .clk(clk), .rst(rst), .rx_en(rx_en), .tick(os_tick),
        .line_s(line_s), .vote(vote), .frm_done(frm_done),
        .frm_data(frm_data), .frm_tail(frm_tail), .busy(busy)
    );

    mp_uart_rx_result #(.DATA_W(DATA_W)) u_res (
        .clk(clk), .rst(rst), .frm_done(frm_done), .frm_data(frm_data),
        .frm_tail(frm_tail), .filt_en(addr_filt_en), .flag_clr(flag_clr),
        .take(take), .rx_byte(rx_byte), .rx_bit9(rx_bit9),
        .frame_err(frame_err), .rx_done(rx_done)
    );

endmodule

// File: rtl/mp_uart_rx_chk.sv
module mp_uart_rx_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              rx_en,
    input logic              addr_filt_en,
    input logic              flag_clr,
    input logic              rx_done,
    input logic [DATA_W-1:0] rx_byte,
    input logic              rx_bit9,
    input logic              frame_err,
    input logic              busy,
    input logic              frm_done,
    input logic              take
);
    a_r2_idle_when_off: assert property (@(posedge clk) disable iff (rst)
        !rx_en |=> !busy);

    a_r3_filtered_rise: assert property (@(posedge clk) disable iff (rst)
        ($rose(rx_done) && $past(addr_filt_en)) |-> (rx_bit9 && !frame_err));

    a_r8_keep_byte: assert property (@(posedge clk) disable iff (rst)
        (rx_done && !flag_clr) |=> $stable(rx_byte));

    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        (rx_done && !flag_clr) |=> rx_done);

    a_r9_clear: assert property (@(posedge clk) disable iff (rst)
        (flag_clr && !take) |=> !rx_done);

    a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
        take |=> rx_done);

    a_r1_rise_from_frame: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_done) |-> $past(frm_done));
endmodule

bind mp_uart_rx mp_uart_rx_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst), .rx_en(rx_en), .addr_filt_en(addr_filt_en),
    .flag_clr(flag_clr), .rx_done(rx_done), .rx_byte(rx_byte),
    .rx_bit9(rx_bit9), .frame_err(frame_err), .busy(busy),
    .frm_done(frm_done), .take(take)
);

// File: tb/tb_mp_uart_rx.sv
module tb_mp_uart_rx;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_line = 1'b1;
    logic       rx_en = 1'b0;
    logic       addr_filt_en = 1'b0;
    logic       os_tick = 1'b0;
    logic       flag_clr = 1'b0;
    logic [7:0] rx_byte;
    logic       rx_bit9;
    logic       rx_done;
    logic       frame_err;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    // Model state
    logic [7:0] m_byte = '0;
    logic       m_b9 = 1'b0;
    logic       m_ferr = 1'b0;
    logic       m_done = 1'b0;

    // Vector: [10] filter, [9] ninth bit, [8] stop level, [7:0] data
    localparam logic [10:0] VEC [8] = '{
        {1'b0, 1'b0, 1'b1, 8'hA5},
        {1'b0, 1'b1, 1'b1, 8'h3C},
        {1'b0, 1'b0, 1'b0, 8'h81},
        {1'b1, 1'b1, 1'b1, 8'h5A},
        {1'b1, 1'b0, 1'b1, 8'h77},
        {1'b1, 1'b1, 1'b0, 8'hE1},
        {1'b1, 1'b0, 1'b0, 8'h12},
        {1'b0, 1'b1, 1'b0, 8'hFF}
    };

    mp_uart_rx dut (
        .clk(clk), .rst(rst), .rx_line(rx_line), .rx_en(rx_en),
        .addr_filt_en(addr_filt_en), .os_tick(os_tick), .flag_clr(flag_clr),
        .rx_byte(rx_byte), .rx_bit9(rx_bit9), .rx_done(rx_done),
        .frame_err(frame_err)
    );

    always #5 clk = ~clk;

    // 16x tick: one pulse every 4 clocks
    initial begin
        forever begin
            for (int k = 0; k < 4; k++) begin
                @(negedge clk);
                os_tick = (k == 3);
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_outputs(input string req);
        chk(req, {31'd0, rx_done}, {31'd0, m_done});
        chk(req, {24'd0, rx_byte}, {24'd0, m_byte});
        chk(req, {31'd0, rx_bit9}, {31'd0, m_b9});
        chk(req, {31'd0, frame_err}, {31'd0, m_ferr});
    endtask

    task automatic send_frame(input logic [7:0] d, input logic b9, input logic stp,
                              input int glitch_bit);
        logic [10:0] bits;
        bits = {stp, b9, d, 1'b0};
        for (int i = 0; i < 11; i++) begin
            for (int c = 0; c < 64; c++) begin
                rx_line = bits[i];
                if (i == glitch_bit && c >= 28 && c < 32) rx_line = ~bits[i];
                @(negedge clk);
            end
        end
        rx_line = 1'b1;
        repeat (192) @(negedge clk);
    endtask

    task automatic clear_flag();
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        @(negedge clk);
        m_done = 1'b0;
    endtask

    // Model of acceptance, written from the requirements
    task automatic model_frame(input logic filt, input logic [7:0] d, input logic b9,
                               input logic stp);
        logic ok;
        ok = filt ? (b9 && stp) : 1'b1;
        if (ok && !m_done && rx_en) begin
            m_byte = d; m_b9 = b9; m_ferr = ~stp; m_done = 1'b1;
        end
    endtask

    initial begin
        repeat (5) @(negedge clk);
        // R10: reset state
        check_outputs("R10 reset");
        rst = 1'b0;
        rx_en = 1'b1;
        repeat (8) @(negedge clk);

        // Table walk: R1 R3 R4 R5
        for (int v = 0; v < 8; v++) begin
            clear_flag();
            chk("R9 clear", {31'd0, rx_done}, 32'd0);
            addr_filt_en = VEC[v][10];
            send_frame(VEC[v][7:0], VEC[v][9], VEC[v][8], -1);
            model_frame(VEC[v][10], VEC[v][7:0], VEC[v][9], VEC[v][8]);
            check_outputs(VEC[v][10] ? "R3 filtered frame" : "R1/R4/R5 open frame");
        end

        // R8: overrun drops the later frame
        addr_filt_en = 1'b0;
        clear_flag();
        send_frame(8'h11, 1'b0, 1'b1, -1);
        model_frame(1'b0, 8'h11, 1'b0, 1'b1);
        send_frame(8'h22, 1'b1, 1'b1, -1);
        model_frame(1'b0, 8'h22, 1'b1, 1'b1);
        check_outputs("R8 overrun keep");

        // R9: flag persists without clear, drops after clear
        repeat (50) @(negedge clk);
        chk("R9 hold", {31'd0, rx_done}, 32'd1);
        clear_flag();
        chk("R9 cleared", {31'd0, rx_done}, 32'd0);

        // R2: receiver disabled ignores a frame
        rx_en = 1'b0;
        send_frame(8'h99, 1'b1, 1'b1, -1);
        check_outputs("R2 disabled");
        rx_en = 1'b1;
        repeat (8) @(negedge clk);

        // R6: short low pulse is no start bit
        rx_line = 1'b0;
        repeat (12) @(negedge clk);
        rx_line = 1'b1;
        repeat (1000) @(negedge clk);
        check_outputs("R6 false start");
        send_frame(8'hC3, 1'b0, 1'b1, -1);
        model_frame(1'b0, 8'hC3, 1'b0, 1'b1);
        check_outputs("R6 recovery");

        // R7: one-tick glitch at mid-bit is outvoted (data bit 0 and ninth bit)
        clear_flag();
        send_frame(8'h5B, 1'b1, 1'b1, 1);
        model_frame(1'b0, 8'h5B, 1'b1, 1'b1);
        check_outputs("R7 glitch data bit");
        clear_flag();
        send_frame(8'h40, 1'b0, 1'b1, 9);
        model_frame(1'b0, 8'h40, 1'b0, 1'b1);
        check_outputs("R7 glitch ninth bit");

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule